// File: doc/BRIEF.md
# Accumulator Execution Unit with Operand Addressing Modes

This unit executes one already-decoded instruction at a time against a single 16-bit accumulator. Each instruction has a 3-bit opcode, a 3-bit addressing-mode selector and an 8-bit field. The field is either a literal, a memory address or a register number. A sequencer resolves the operand through zero, one or two memory reads, depending on the mode. The unit then loads the accumulator, stores it, or combines the operand with it in an arithmetic operation. Two implied operations ignore the mode and the field entirely.

The unit drives a synchronous single-port memory. A read is issued in one cycle and its data is valid in the next. The unit holds eight 16-bit general registers. A store in register mode is the only way to write them. A caller presents an instruction with `start` while `busy` is low. It then waits for the one-cycle `done` pulse. At that pulse the accumulator, carry and error outputs already hold the result.

Top module: `acc_unit`

## Requirements
- R1: After synchronous reset, `acc`, `carry`, `err`, `done` and `busy` are all 0 and all eight registers hold 0.
- R2: Immediate mode (mode 0) uses the 8-bit field, zero-extended, as the operand. It issues no memory access, and `done` is high 2 cycles after the edge that sampled `start`.
- R3: Direct mode (mode 1) reads memory once at the field address and uses the returned word as the operand. `done` follows 3 cycles after start.
- R4: Indirect mode (mode 2) reads the word at the field address and takes its low 8 bits as a pointer. It then reads the operand at that pointer: two reads in total, with `done` 4 cycles after start.
- R5: Register mode (mode 3) uses register `field[2:0]` as the operand and makes no memory access.
- R6: Register-indirect mode (mode 4) reads memory once at the low 8 bits of register `field[2:0]`. `done` follows 3 cycles after start.
- R7: Store (opcode 1) makes no operand read. In direct, indirect and register-indirect modes it writes `acc` to the effective address with a single write; indirect mode first reads the pointer. In register mode it writes `acc` into register `field[2:0]`. In immediate mode it changes nothing. `done` comes 2 cycles after start, plus one for each read.
- R8: Load (0) copies the operand into `acc`. Add (2) sets `carry` to the carry out. Subtract (3) sets `carry` to the borrow, that is `acc` < operand. Multiply (4) keeps the low 16 bits of the product. Divide (5) keeps the unsigned quotient. Multiply and divide leave `carry` unchanged.
- R9: Divide by a zero operand leaves `acc` unchanged and sets `err`. Every retirement rewrites `err`, so any other instruction clears it.
- R10: Clear-carry (6) clears `carry` and clear-accumulator (7) clears `acc`. Both ignore mode and field, make no memory access and retire 2 cycles after start.
- R11: `start` is ignored while `busy` is high, and `done` is high for exactly one cycle per instruction.
- R12: Reserved mode values 5 to 7 behave exactly as immediate mode.
- R13: The memory port is silent (`mem_re` and `mem_we` low) while the unit is idle, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the presented instruction (sampled only when idle) |
| opcode | input | 3 | Operation code |
| mode | input | 3 | Addressing-mode selector |
| field | input | 8 | Literal, address or register number |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle retirement pulse |
| acc | output | 16 | Accumulator |
| carry | output | 1 | Carry / borrow flag |
| err | output | 1 | Last retired instruction divided by zero |
| mem_addr | output | 8 | Memory address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the request |

## Verification
The bench measures latency and read/write counts for every mode, which shows an extra or missing sequencer state or a pointer read taken in the wrong cycle. It gives the pointer word nonzero upper bits, so a design that forwarded all 16 bits would address the wrong location. A design that latched a new instruction while busy would corrupt the running result; the bench holds `start` high through a busy instruction with a different instruction on the inputs to catch this. Divide by zero followed by an add checks that the accumulator survives and that the error flag is not left stuck.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int unsigned ACC_DATA_W = 16;
    localparam int unsigned ACC_ADDR_W = 8;
    localparam int unsigned ACC_NREGS  = 8;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_ADD   = 3'd2,
        OP_SUB   = 3'd3,
        OP_MUL   = 3'd4,
        OP_DIV   = 3'd5,
        OP_CLRC  = 3'd6,
        OP_CLRA  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        AM_IMM  = 3'd0,
        AM_DIR  = 3'd1,
        AM_IND  = 3'd2,
        AM_REG  = 3'd3,
        AM_RIND = 3'd4,
        AM_RS5  = 3'd5,
        AM_RS6  = 3'd6,
        AM_RS7  = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_PTR  = 2'd1,
        SQ_OPND = 2'd2,
        SQ_EXEC = 2'd3
    } seq_e;

    typedef struct packed {
        opcode_e op;
        amode_e  mode;
    } ctl_t;

    function automatic logic is_implied(opcode_e op);
        return (op == OP_CLRC) || (op == OP_CLRA);
    endfunction

    function automatic amode_e norm_mode(logic [2:0] m);
        amode_e r;
        case (m)
            3'd1:    r = AM_DIR;
            3'd2:    r = AM_IND;
            3'd3:    r = AM_REG;
            3'd4:    r = AM_RIND;
            default: r = AM_IMM;
        endcase
        return r;
    endfunction

    function automatic logic is_mem_mode(amode_e m);
        return (m == AM_DIR) || (m == AM_IND) || (m == AM_RIND);
    endfunction

    function automatic logic needs_read(ctl_t c);
        return is_mem_mode(c.mode) &&
               (c.op inside {OP_LOAD, OP_ADD, OP_SUB, OP_MUL, OP_DIV});
    endfunction

endpackage

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NUM_REGS = 8,
    localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rsel,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (wsel == SEL_W'(g))) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata = regs[rsel];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd,
    input  logic              carry_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              carry_out,
    output logic              err_out
);

    logic [DATA_W:0]     sum;
    logic [DATA_W:0]     diff;
    logic [2*DATA_W-1:0] prod;

    always_comb begin
        sum       = {1'b0, acc_in} + {1'b0, opnd};
        diff      = {1'b0, acc_in} - {1'b0, opnd};
        prod      = acc_in * opnd;
        acc_out   = acc_in;
        carry_out = carry_in;
        err_out   = 1'b0;
        case (op)
            OP_LOAD:  acc_out = opnd;
            OP_ADD: begin
                acc_out   = sum[DATA_W-1:0];
                carry_out = sum[DATA_W];
            end
            OP_SUB: begin
                acc_out   = diff[DATA_W-1:0];
                carry_out = diff[DATA_W];
            end
            OP_MUL:   acc_out = prod[DATA_W-1:0];
            OP_DIV: begin
                if (opnd == '0) begin
                    err_out = 1'b1;
                end else begin
                    acc_out = acc_in / opnd;
                end
            end
            OP_CLRC:  carry_out = 1'b0;
            OP_CLRA:  acc_out = '0;
            default:  acc_out = acc_in;
        endcase
    end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  ctl_t ctl_i,
    output ctl_t ctl_o,
    output seq_e state_o,
    output logic ptr_live_o,
    output logic done_o
);

    seq_e st, nx;
    ctl_t ctl_q;
    logic ptr_live_q;
    logic done_q;

    always_comb begin
        nx = st;
        case (st)
            SQ_IDLE: begin
                if (start) begin
                    if (ctl_i.mode == AM_IND && !is_implied(ctl_i.op)) begin
                        nx = SQ_PTR;
                    end else if (needs_read(ctl_i)) begin
                        nx = SQ_OPND;
                    end else begin
                        nx = SQ_EXEC;
                    end
                end
            end
            SQ_PTR:  nx = (ctl_q.op == OP_STORE) ? SQ_EXEC : SQ_OPND;
            SQ_OPND: nx = SQ_EXEC;
            SQ_EXEC: nx = SQ_IDLE;
            default: nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SQ_IDLE;
            ctl_q      <= '{op: OP_LOAD, mode: AM_IMM};
            ptr_live_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            st         <= nx;
            ptr_live_q <= (st == SQ_PTR);
            done_q     <= (st == SQ_EXEC);
            if (st == SQ_IDLE && start) begin
                ctl_q <= ctl_i;
            end
        end
    end

    assign ctl_o      = ctl_q;
    assign state_o    = st;
    assign ptr_live_o = ptr_live_q;
    assign done_o     = done_q;

endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
#(
    parameter int unsigned DATA_W   = ACC_DATA_W,
    parameter int unsigned ADDR_W   = ACC_ADDR_W,
    parameter int unsigned NUM_REGS = ACC_NREGS,
    localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        opcode,
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] field,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] acc,
    output logic              carry,
    output logic              err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    ctl_t              ctl_in;
    ctl_t              ctl_q;
    seq_e              st;
    logic              ptr_live;
    logic              exec;
    logic [DATA_W-1:0] val_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] rf_rdata;
    logic              rf_we;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] acc_q, alu_acc;
    logic              carry_q, alu_carry;
    logic              err_q, alu_err;

    always_comb begin
        ctl_in.op   = opcode_e'(opcode);
        ctl_in.mode = is_implied(ctl_in.op) ? AM_IMM : norm_mode(mode);
    end

    acc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ctl_i      (ctl_in),
        .ctl_o      (ctl_q),
        .state_o    (st),
        .ptr_live_o (ptr_live),
        .done_o     (done)
    );

    acc_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .wsel  (sel_q),
        .wdata (acc_q),
        .rsel  (field[SEL_W-1:0]),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            sel_q <= '0;
        end else if (st == SQ_IDLE && start) begin
            sel_q <= field[SEL_W-1:0];
            if (ctl_in.mode == AM_REG || ctl_in.mode == AM_RIND) begin
                val_q <= rf_rdata;
            end else begin
                val_q <= {{(DATA_W-ADDR_W){1'b0}}, field};
            end
        end
    end

    assign exec = (st == SQ_EXEC);
    assign ea   = ptr_live ? mem_rdata[ADDR_W-1:0] : val_q[ADDR_W-1:0];
    assign opnd = needs_read(ctl_q) ? mem_rdata : val_q;

    acc_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op        (ctl_q.op),
        .acc_in    (acc_q),
        .opnd      (opnd),
        .carry_in  (carry_q),
        .acc_out   (alu_acc),
        .carry_out (alu_carry),
        .err_out   (alu_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (exec) begin
            acc_q   <= alu_acc;
            carry_q <= alu_carry;
            err_q   <= alu_err;
        end
    end

    assign rf_we     = exec && ctl_q.op == OP_STORE && ctl_q.mode == AM_REG;
    assign mem_re    = (st == SQ_PTR) || (st == SQ_OPND);
    assign mem_we    = exec && ctl_q.op == OP_STORE && is_mem_mode(ctl_q.mode);
    assign mem_addr  = ea;
    assign mem_wdata = acc_q;
    assign busy      = (st != SQ_IDLE);
    assign acc       = acc_q;
    assign carry     = carry_q;
    assign err       = err_q;

endmodule

// File: rtl/acc_unit_chk.sv
module acc_unit_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] acc,
    input logic              err,
    input logic              mem_re,
    input logic              mem_we
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done wider than one cycle"); // R11

    AST_BUSY_NO_DONE_NEXT_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done)) else $error("start not accepted"); // R11

    AST_ACC_ONLY_AT_RETIRE: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc) |-> done) else $error("acc changed outside retirement"); // R8

    AST_DIV0_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(acc)) else $error("acc moved with err set"); // R9

    AST_IDLE_MEM_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_re && !mem_we)) else $error("memory access while idle"); // R13

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)) else $error("read and write together"); // R13

endmodule

bind acc_unit acc_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .acc    (acc),
    .err    (err),
    .mem_re (mem_re),
    .mem_we (mem_we)
);

// File: tb/acc_unit_bench.sv
module acc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [2:0]  mode = '0;
    logic [7:0]  field = '0;
    logic        busy, done, carry, err, mem_re, mem_we;
    logic [15:0] acc, mem_wdata;
    logic [7:0]  mem_addr;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem [256];

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    acc_unit u_acc_unit (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .mode(mode),
        .field(field), .busy(busy), .done(done), .acc(acc), .carry(carry),
        .err(err), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [2:0] md, input logic [7:0] f,
                       output int lat, output int rd, output int wr);
        @(negedge clk);
        opcode = op; mode = md; field = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1; rd = 0; wr = 0;
        while (!done && lat < 60) begin
            rd += int'(mem_re);
            wr += int'(mem_we);
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset;
        chk("R1 acc", acc, 0);
        chk("R1 carry", carry, 0);
        chk("R1 err", err, 0);
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_imm;
        int l, r, w;
        run(3'd0, 3'd0, 8'h5A, l, r, w);
        chk("R2 load imm", acc, 16'h005A);
        chk("R2 latency", l, 2);
        chk("R2 reads", r, 0);
        run(3'd2, 3'd0, 8'h05, l, r, w);
        chk("R2 add imm", acc, 16'h005F);
        @(negedge clk);
        chk("R11 done pulse width", done, 0);
        chk("R13 idle re", mem_re, 0);
        chk("R13 idle we", mem_we, 0);
    endtask

    task automatic t_direct;
        int l, r, w;
        mem[8'h10] = 16'h1234;
        run(3'd0, 3'd1, 8'h10, l, r, w);
        chk("R3 load dir", acc, 16'h1234);
        chk("R3 latency", l, 3);
        chk("R3 reads", r, 1);
    endtask

    task automatic t_indirect;
        int l, r, w;
        mem[8'h20] = 16'hAB30;
        mem[8'h30] = 16'h0777;
        run(3'd7, 3'd0, 8'h00, l, r, w);
        run(3'd2, 3'd2, 8'h20, l, r, w);
        chk("R4 add ind", acc, 16'h0777);
        chk("R4 latency", l, 4);
        chk("R4 reads", r, 2);
    endtask

    task automatic t_store_reg;
        int l, r, w;
        run(3'd0, 3'd0, 8'h42, l, r, w);
        run(3'd1, 3'd3, 8'h03, l, r, w);
        chk("R7 store reg latency", l, 2);
        chk("R7 store reg writes", w, 0);
        run(3'd0, 3'd0, 8'h00, l, r, w);
        run(3'd0, 3'd3, 8'h03, l, r, w);
        chk("R5 load reg", acc, 16'h0042);
        chk("R5 reads", r, 0);
        run(3'd0, 3'd3, 8'h04, l, r, w);
        chk("R5 other reg untouched", acc, 16'h0000);
        run(3'd0, 3'd3, 8'h03, l, r, w);
        run(3'd1, 3'd1, 8'h50, l, r, w);
        chk("R7 store dir mem", mem[8'h50], 16'h0042);
        chk("R7 store dir latency", l, 2);
        chk("R7 store dir writes", w, 1);
        run(3'd1, 3'd2, 8'h20, l, r, w);
        chk("R7 store ind mem", mem[8'h30], 16'h0042);
        chk("R7 store ind latency", l, 3);
        chk("R7 store ind reads", r, 1);
        chk("R7 store ind writes", w, 1);
        mem[8'h61] = 16'hBEEF;
        run(3'd1, 3'd0, 8'h61, l, r, w);
        chk("R7 store imm no write", w, 0);
        chk("R7 store imm mem kept", mem[8'h61], 16'hBEEF);
        chk("R7 store imm acc kept", acc, 16'h0042);
    endtask

    task automatic t_rind;
        int l, r, w;
        mem[8'h42] = 16'h1111;
        run(3'd0, 3'd4, 8'h03, l, r, w);
        chk("R6 load rind", acc, 16'h1111);
        chk("R6 latency", l, 3);
        chk("R6 reads", r, 1);
    endtask

    task automatic t_arith;
        int l, r, w;
        run(3'd0, 3'd0, 8'hFF, l, r, w);
        run(3'd4, 3'd0, 8'hFF, l, r, w);
        chk("R8 mul low", acc, 16'hFE01);
        mem[8'h60] = 16'h0200;
        run(3'd2, 3'd1, 8'h60, l, r, w);
        chk("R8 add wrap", acc, 16'h0001);
        chk("R8 add carry", carry, 1);
        run(3'd3, 3'd0, 8'h02, l, r, w);
        chk("R8 sub wrap", acc, 16'hFFFF);
        chk("R8 sub borrow", carry, 1);
        run(3'd6, 3'd1, 8'h10, l, r, w);
        chk("R10 clc", carry, 0);
        chk("R10 clc acc kept", acc, 16'hFFFF);
        chk("R10 clc reads", r, 0);
        run(3'd0, 3'd0, 8'hC8, l, r, w);
        run(3'd5, 3'd0, 8'h07, l, r, w);
        chk("R8 div", acc, 16'd28);
        chk("R8 div err clear", err, 0);
        run(3'd5, 3'd0, 8'h00, l, r, w);
        chk("R9 div0 acc", acc, 16'd28);
        chk("R9 div0 err", err, 1);
        run(3'd2, 3'd0, 8'h01, l, r, w);
        chk("R9 err cleared", err, 0);
        chk("R9 add after", acc, 16'd29);
    endtask

    task automatic t_implied_reserved;
        int l, r, w;
        run(3'd7, 3'd2, 8'h20, l, r, w);
        chk("R10 cla", acc, 0);
        chk("R10 cla latency", l, 2);
        chk("R10 cla reads", r, 0);
        run(3'd0, 3'd5, 8'h33, l, r, w);
        chk("R12 mode5", acc, 16'h0033);
        chk("R12 mode5 reads", r, 0);
        run(3'd2, 3'd7, 8'h01, l, r, w);
        chk("R12 mode7", acc, 16'h0034);
        chk("R12 mode7 latency", l, 2);
    endtask

    task automatic t_busy;
        int lat = 0;
        int rd = 0;
        mem[8'h20] = 16'h0030;
        mem[8'h30] = 16'h2222;
        @(negedge clk);
        opcode = 3'd0; mode = 3'd2; field = 8'h20; start = 1'b1;
        @(negedge clk);
        opcode = 3'd7; mode = 3'd0; field = 8'h00;
        lat = 1;
        while (!done && lat < 60) begin
            if (lat == 3) start = 1'b0;
            rd += int'(mem_re);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R11 busy start ignored acc", acc, 16'h2222);
        chk("R11 busy start latency", lat, 4);
        chk("R11 busy start reads", rd, 2);
        @(negedge clk);
        chk("R11 no relaunch", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_imm();
        t_direct();
        t_indirect();
        t_store_reg();
        t_rind();
        t_arith();
        t_implied_reserved();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule